// File: doc/BRIEF.md
# Push-Button LED Toggle with Per-Channel Lockout

This block turns momentary push-buttons into on/off switches for LEDs. Each channel pairs one button with one LED. A press flips that channel's stored LED bit. The channel then stops listening to its button for a fixed number of clock cycles, so a press held by a human hand counts as one event instead of millions. Every channel owns its own down-counter, so a lockout on one channel never delays another.

The lockout begins at the toggle itself. Releasing the button plays no part in it. A button still held when the count runs out therefore flips the LED again and starts a new lockout, which gives a steady blink while the button is held.

Buttons pass through a two-flop synchroniser before the toggle logic sees them. The LED outputs come straight from an internal state register and are never read back. The reload value is a parameter: the default of 10,000,000 gives about 100 ms at 100 MHz, and a bench can shorten it.

Top module: `led_toggle_lock`

## Requirements
- R1: While `rst_n` is low at a clock edge, all LED outputs go to 0 and every lockout counter goes to 0. The first press after reset is therefore accepted at once.
- R2: A button reads as pressed when its input bit is 1. When a channel is idle (counter at 0), a press on it inverts its LED on the third rising clock edge after the input rises: two edges for the synchroniser and one for the state register.
- R3: Button bit i affects only LED bit i. The other LED bits keep their values.
- R4: While a channel's counter is nonzero, its button has no effect on its LED.
- R5: A toggle loads the channel's counter with `LOCKOUT_CYCLES`. The counter then falls by one per cycle, so the lockout lasts exactly that many cycles.
- R6: A button held continuously toggles its LED every `LOCKOUT_CYCLES`+1 cycles.
- R7: Presses that reach several idle channels on the same edge toggle all of those LEDs on that same edge. Each channel then counts its lockout on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_i | input | NUM_CH (4) | Raw button levels, 1 = pressed |
| led_o | output | NUM_CH (4) | LED drive, copy of the internal state register |

## Verification
A counter that is wrong inside a channel shows up at the ports in one of two ways:
- A held button blinks with the wrong period.
- A press during lockout flips the LED, or a press after lockout is lost.

Either difference appears within one lockout period plus three cycles of the stimulus. A wrong LED state bit shows on `led_o` in the cycle after it is written, because the output is the register itself. The bench therefore compares every output bit on every cycle against a cycle-accurate model built from the requirements. This catches both kinds of fault at the first cycle where they diverge.

// File: rtl/led_lock_pkg.sv
// Package: shared defaults and a width helper for the LED lockout block.
// Assumes: the reload value fits in 32 bits.
package led_lock_pkg;
    localparam int DEF_NUM_CH   = 4;
    localparam int DEF_LOCKOUT  = 10_000_000;
    localparam int DEF_SYNC_STG = 2;

    // Bits needed to hold values 0..max_val.
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction
endpackage

// File: rtl/btn_sync.sv
// Module: btn_sync
// Multi-stage flop synchroniser for a vector of slow asynchronous levels.
// Assumes: each bit is independent and held far longer than one clock period;
// no bus coherence between bits is needed.
module btn_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg_q [STAGES];

    // Shift the raw levels through the flop chain; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
        end else begin
            stg_q[0] <= din;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/lock_channel.sv
// Module: lock_channel
// One button/LED pair: flips the stored LED bit on a press seen while idle,
// then ignores the button for LOCKOUT cycles using a down-counter.
// Assumes: press_i is already synchronous to clk.
module lock_channel
    import led_lock_pkg::*;
#(
    parameter int LOCKOUT = DEF_LOCKOUT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic press_i,
    output logic led_q
);
    localparam int CNT_W = cnt_width(LOCKOUT);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LOCKOUT);

    logic [CNT_W-1:0] cnt_q;
    logic             idle;

    assign idle = (cnt_q == '0);

    // Toggle on an accepted press and load the lockout; otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q <= 1'b0;
            cnt_q <= '0;
        end else if (press_i && idle) begin
            led_q <= ~led_q;
            cnt_q <= RELOAD;
        end else if (!idle) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    AST_LOCK_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(led_q)); // R4
    AST_RELOAD_ON_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (press_i && idle) |=> (cnt_q == RELOAD) && (led_q != $past(led_q))); // R5
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!press_i && idle) |=> $stable(led_q) && (cnt_q == '0)); // R2
endmodule

// File: rtl/led_toggle_lock.sv
// Module: led_toggle_lock (top)
// NUM_CH independent button-to-LED toggle channels, each with its own lockout.
// Assumes: btn_i is asynchronous, active high; led_o drives pins and is never read.
module led_toggle_lock
    import led_lock_pkg::*;
#(
    parameter int NUM_CH         = DEF_NUM_CH,
    parameter int LOCKOUT_CYCLES = DEF_LOCKOUT,
    parameter int SYNC_STAGES    = DEF_SYNC_STG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] btn_i,
    output logic [NUM_CH-1:0] led_o
);
    logic [NUM_CH-1:0] btn_s;
    logic [NUM_CH-1:0] led_state;

    btn_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (btn_i),
        .dout (btn_s)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        lock_channel #(.LOCKOUT(LOCKOUT_CYCLES)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .press_i(btn_s[i]),
            .led_q  (led_state[i])
        );
    end

    assign led_o = led_state;
endmodule

// File: tb/sim_led_toggle_lock.sv
`timescale 1ns/1ps
module sim_led_toggle_lock;
    localparam int N = 4;
    localparam int L = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] btn = '0;
    logic [N-1:0] led_o;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] m_s1 = '0, m_s2 = '0, m_led = '0;
    int           m_cnt [N];

    always #5 clk = ~clk;

    led_toggle_lock #(.NUM_CH(N), .LOCKOUT_CYCLES(L), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .btn_i(btn), .led_o(led_o)
    );

    task automatic model_reset();
        m_s1 = '0; m_s2 = '0; m_led = '0;
        for (int i = 0; i < N; i++) m_cnt[i] = 0;
    endtask

    // One clock edge of the required behaviour (R2, R4, R5, R6).
    task automatic model_edge(input logic [N-1:0] b);
        for (int i = 0; i < N; i++) begin
            if (m_s2[i] && m_cnt[i] == 0) begin
                m_led[i] = ~m_led[i];
                m_cnt[i] = L;
            end else if (m_cnt[i] > 0) begin
                m_cnt[i] = m_cnt[i] - 1;
            end
        end
        m_s2 = m_s1;
        m_s1 = b;
    endtask

    task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: led_o=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [N-1:0] b, input string tag);
        btn = b;
        @(posedge clk);
        #1 model_edge(b);
        @(negedge clk);
        check(led_o, m_led, tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        finish_run();
    end

    initial begin
        int toggles;
        logic prev;
        logic [N-1:0] cur;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(led_o, 4'b0000, "R1 reset");
        rst_n = 1'b1;

        // R2/R3: single press on channel 1, exact latency of three edges
        btn = 4'b0010;
        @(negedge clk); check(led_o, 4'b0000, "R2 latency edge1");
        @(negedge clk); check(led_o, 4'b0000, "R2 latency edge2");
        @(negedge clk); check(led_o, 4'b0010, "R2 R3 toggle edge3");
        for (int i = 0; i < 3; i++) model_edge(4'b0010);
        step(4'b0000, "R4 release");
        // R4: re-press inside lockout has no effect
        repeat (4) step(4'b0010, "R4 press in lockout");
        repeat (4) step(4'b0000, "R4 release");
        check(led_o, 4'b0010, "R4 LED unchanged after lockout press");
        repeat (L) step(4'b0000, "R5 lockout drains");

        // R7: simultaneous presses on channels 0, 2, 3
        repeat (2) step(4'b1101, "R7 simultaneous");
        step(4'b0000, "R7 simultaneous");
        check(led_o, 4'b1111, "R7 three channels toggled together");
        repeat (L + 2) step(4'b0000, "R7 idle");

        // R6: hold channel 3, count toggles over a window
        toggles = 0;
        prev = led_o[3];
        for (int k = 0; k < 3 * (L + 1); k++) begin
            step(4'b1000, "R6 held button");
            if (led_o[3] != prev) toggles++;
            prev = led_o[3];
        end
        checks++;
        if (toggles != 3) begin
            errors++;
            $display("FAIL R6: toggles=%0d expected 3", toggles);
        end
        repeat (L + 2) step(4'b0000, "R6 release");

        // Mixed random stimulus, model compared every cycle (R2-R7)
        cur = '0;
        for (int k = 0; k < 800; k++) begin
            if ($urandom_range(7, 0) == 0) cur = N'($urandom());
            step(cur, "R2 R3 R4 R5 R6 R7 random");
        end

        // R1: reset mid-activity clears LEDs and counters
        btn = 4'b1111;
        rst_n = 1'b0;
        @(posedge clk); #1 model_reset();
        @(negedge clk); check(led_o, 4'b0000, "R1 reset mid-run");
        btn = 4'b0000;
        rst_n = 1'b1;
        repeat (2) step(4'b0100, "R1 first press after reset");
        step(4'b0000, "R1 first press after reset");
        check(led_o, 4'b0100, "R1 counter zero after reset");

        finish_run();
    end
endmodule